// File: doc/BRIEF.md
# Interrupt Set-Pending Register Bank

This block holds the pending state for a range of shared peripheral interrupts and exposes it as a bank of 32-bit registers on a simple single-cycle bus. Register `n` covers interrupts `32n` to `32n+31` of the range. Writing a one to a bit makes that interrupt pending. A read returns the current pending view of the register.

Each interrupt has a software latch that is kept apart from its level-sensitive input line. The pending view is the OR of the two, so a pending state set by software survives after the line drops. Downstream logic clears the latch through a dedicated clear vector, for example on acknowledge. Accesses are masked per bit in three cases:
- the interrupt is not implemented;
- its register lies beyond the configured range;
- the interrupt is secure and a non-secure access is made while security is enforced.

A per-interrupt active flag comes in, and an active-and-pending vector goes out next to the plain pending vector.

Top module: `irq_setpend_bank`

## Requirements
- R1: Register `n` decodes at byte address `0x1600 + 4n` for `n` below `NUM_REGS`, and bit `b` of it maps to interrupt `32n + b`. An address below the base, at or above `0x1600 + 4*NUM_REGS`, or with either of its two low bits set, reads as zero and its writes change nothing.
- R2: Writing a 1 to an accessible bit sets that interrupt's software latch. Writing a 0 changes nothing. Writing a 1 to an interrupt that is already pending, by latch or by line, leaves it pending.
- R3: A read returns, per accessible bit, the latch OR the level input. `rd_data` takes that value at the clock edge that samples the read request, and holds it until the next read request.
- R4: A latch set while the level input is high stays set after the line falls. A 1 on `pend_clr` clears that interrupt's latch.
- R5: If a set by write and a `pend_clr` hit the same interrupt in the same cycle, the latch ends up set.
- R6: With `ext_en` at 0, or for a register index above `range_cfg`, every bit reads as zero and ignores writes.
- R7: An interrupt whose `impl_mask` bit is 0 reads as zero, ignores writes and never appears on `pend_out`.
- R8: With `sec_disable` at 0 and `req_nonsec` at 1, bits whose `secure_mask` bit is 1 read as zero and ignore writes. Secure accesses, or any access while `sec_disable` is 1, reach those bits.
- R9: After reset every latch is clear and `rd_data` is zero.
- R10: `pend_out` is the pending view restricted to implemented interrupts in enabled registers, and `act_pend_out` is `pend_out` AND `active_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Enables the whole register range |
| range_cfg | input | RNG_W | Highest implemented register index |
| sec_disable | input | 1 | 1 lets non-secure accesses reach secure interrupts |
| secure_mask | input | NIRQ | 1 marks a secure interrupt |
| impl_mask | input | NIRQ | 1 marks an implemented interrupt |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_nonsec | input | 1 | 1 = non-secure access |
| rd_data | output | 32 | Registered read data |
| irq_level | input | NIRQ | Level-sensitive interrupt lines |
| pend_clr | input | NIRQ | Per-interrupt latch clear |
| active_in | input | NIRQ | Per-interrupt active flag |
| pend_out | output | NIRQ | Pending view for downstream logic |
| act_pend_out | output | NIRQ | Active-and-pending vector |

## Verification
The two actions that can land on one interrupt in the same cycle are a set by bus write and a clear on `pend_clr`. The bench drives both for a chosen bit on one clock edge. It expects the set to win, and reads the bit back through the bus and through `pend_out`. A second collision is a latch set while the level line is already high. The bench drops the line on a later cycle and expects the interrupt to stay pending until an explicit clear arrives.

// File: rtl/irq_setpend_pkg.sv
package irq_setpend_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned IDX_MAX_W = 8;

  typedef struct packed {
    logic                 hit;
    logic                 rd;
    logic                 wr;
    logic [IDX_MAX_W-1:0] idx;
  } bus_dec_t;
endpackage

// File: rtl/isp_addr_dec.sv
module isp_addr_dec
  import irq_setpend_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h1600,
  parameter int unsigned NUM_REGS  = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output bus_dec_t          dec
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_REGS);

  logic [ADDR_W-1:0] off;
  logic              in_win;

  always_comb begin
    off     = req_addr - BASE;
    in_win  = (req_addr >= BASE) && (off < SPAN) && (off[1:0] == 2'b00);
    dec.hit = req_valid && in_win;
    dec.rd  = req_valid && !req_write;
    dec.wr  = req_valid && req_write && in_win;
    dec.idx = IDX_MAX_W'(off >> 2);
  end
endmodule

// File: rtl/isp_access_mask.sv
module isp_access_mask #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned RNG_W    = 2,
  localparam int unsigned NIRQ    = NUM_REGS * 32
) (
  input  logic             ext_en,
  input  logic [RNG_W-1:0] range_cfg,
  input  logic             sec_disable,
  input  logic             req_nonsec,
  input  logic [NIRQ-1:0]  secure_mask,
  input  logic [NIRQ-1:0]  impl_mask,
  output logic [NIRQ-1:0]  impl_eff,
  output logic [NIRQ-1:0]  acc_ok
);
  logic sec_block;
  assign sec_block = req_nonsec && !sec_disable;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic reg_on;
    assign reg_on = ext_en && ({1'b0, range_cfg} >= (RNG_W+1)'(r));
    for (genvar b = 0; b < 32; b++) begin : g_bit
      localparam int unsigned I = r * 32 + b;
      assign impl_eff[I] = reg_on && impl_mask[I];
      assign acc_ok[I]   = impl_eff[I] && !(sec_block && secure_mask[I]);
    end
  end
endmodule

// File: rtl/isp_pend_latch.sv
module isp_pend_latch #(
  parameter int unsigned NIRQ = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_vec,
  input  logic [NIRQ-1:0] clr_vec,
  input  logic [NIRQ-1:0] level,
  output logic [NIRQ-1:0] view
);
  logic [NIRQ-1:0] lat_q;
  logic [NIRQ-1:0] lat_d;
  logic            lat_en;

  always_comb begin
    lat_en = |(set_vec | clr_vec);
    lat_d  = (lat_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign view = lat_q | level;

  // R4: a set latch only drops after a clear request
  assert_latch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lat_q) & ~$past(clr_vec) & ~lat_q) == '0));
  // R2: a latch only rises where a set was requested
  assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(lat_q) & lat_q & ~$past(set_vec)) == '0));
  // R5: set wins over a clear in the same cycle
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(set_vec) & $past(clr_vec)) & ~lat_q) == '0));
endmodule

// File: rtl/irq_setpend_bank.sv
module irq_setpend_bank
  import irq_setpend_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h1600,
  localparam int unsigned NIRQ     = NUM_REGS * 32,
  localparam int unsigned RNG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic [RNG_W-1:0]  range_cfg,
  input  logic              sec_disable,
  input  logic [NIRQ-1:0]   secure_mask,
  input  logic [NIRQ-1:0]   impl_mask,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_nonsec,
  output logic [31:0]       rd_data,
  input  logic [NIRQ-1:0]   irq_level,
  input  logic [NIRQ-1:0]   pend_clr,
  input  logic [NIRQ-1:0]   active_in,
  output logic [NIRQ-1:0]   pend_out,
  output logic [NIRQ-1:0]   act_pend_out
);
  bus_dec_t        dec;
  logic [NIRQ-1:0] impl_eff;
  logic [NIRQ-1:0] acc_ok;
  logic [NIRQ-1:0] set_vec;
  logic [NIRQ-1:0] view;
  logic [31:0]     rd_next;
  logic            rd_en;

  isp_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .dec(dec)
  );

  isp_access_mask #(.NUM_REGS(NUM_REGS), .RNG_W(RNG_W)) u_mask (
    .ext_en(ext_en), .range_cfg(range_cfg), .sec_disable(sec_disable),
    .req_nonsec(req_nonsec), .secure_mask(secure_mask), .impl_mask(impl_mask),
    .impl_eff(impl_eff), .acc_ok(acc_ok)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_set
    logic sel;
    assign sel = dec.wr && (dec.idx == IDX_MAX_W'(r));
    assign set_vec[r*32 +: 32] = sel ? (req_wdata & acc_ok[r*32 +: 32]) : '0;
  end

  isp_pend_latch #(.NIRQ(NIRQ)) u_lat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(pend_clr),
    .level(irq_level), .view(view)
  );

  always_comb begin
    rd_en   = dec.rd;
    rd_next = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (dec.hit && (dec.idx == IDX_MAX_W'(r)))
        rd_next = view[r*32 +: 32] & acc_ok[r*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign pend_out     = view & impl_eff;
  assign act_pend_out = pend_out & active_in;

  // R8: non-secure writes never reach secure bits while enforcement is on
  assert_ns_no_secure_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_nonsec && !sec_disable) |-> ((set_vec & secure_mask) == '0));
  // R7: unimplemented interrupts are never set
  assert_unimpl_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & ~impl_mask) == '0));
  // R1: a read outside the window returns zero
  assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !dec.hit) |=> (rd_data == '0));
  // R3: read data holds between read requests
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rd_data));
  // R10: pending output stays within implemented interrupts
  assert_pend_impl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_out & ~impl_mask) == '0));
endmodule

// File: tb/sim_irq_setpend_bank.sv
module sim_irq_setpend_bank;
  localparam int NR = 4;
  localparam int NI = NR * 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          ext_en = 1;
  logic [1:0]    range_cfg = 2'd2;
  logic          sec_disable = 0;
  logic [NI-1:0] secure_mask, impl_mask;
  logic          req_valid = 0, req_write = 0, req_nonsec = 0;
  logic [15:0]   req_addr = 0;
  logic [31:0]   req_wdata = 0;
  logic [31:0]   rd_data;
  logic [NI-1:0] irq_level = '0, pend_clr = '0, active_in = '0;
  logic [NI-1:0] pend_out, act_pend_out;

  logic [NI-1:0] mlat = '0;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  irq_setpend_bank u0 (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .range_cfg(range_cfg),
    .sec_disable(sec_disable), .secure_mask(secure_mask), .impl_mask(impl_mask),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_nonsec(req_nonsec), .rd_data(rd_data),
    .irq_level(irq_level), .pend_clr(pend_clr), .active_in(active_in),
    .pend_out(pend_out), .act_pend_out(act_pend_out)
  );

  function automatic bit implemented(int i);
    return ext_en && ((i / 32) <= int'(range_cfg)) && impl_mask[i];
  endfunction

  function automatic bit ok(int i, bit ns);
    return implemented(i) && !(ns && !sec_disable && secure_mask[i]);
  endfunction

  function automatic logic [31:0] exp_read(logic [15:0] a, bit ns);
    logic [31:0] v = '0;
    int off = int'(a) - 'h1600;
    if (off < 0 || off >= 4 * NR || (off % 4) != 0) return '0;
    for (int b = 0; b < 32; b++) begin
      int i = (off / 4) * 32 + b;
      v[b] = (mlat[i] | irq_level[i]) & ok(i, ns);
    end
    return v;
  endfunction

  function automatic logic [NI-1:0] exp_pend();
    logic [NI-1:0] v;
    for (int i = 0; i < NI; i++) v[i] = (mlat[i] | irq_level[i]) & implemented(i);
    return v;
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkv(string req, logic [NI-1:0] act, logic [NI-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [31:0] d, bit ns, logic [NI-1:0] clr);
    int off = int'(a) - 'h1600;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_nonsec = ns;
    pend_clr = clr;
    @(negedge clk);
    req_valid = 0; pend_clr = '0;
    mlat = mlat & ~clr;
    if (off >= 0 && off < 4 * NR && (off % 4) == 0)
      for (int b = 0; b < 32; b++)
        if (d[b] && ok((off / 4) * 32 + b, ns)) mlat[(off / 4) * 32 + b] = 1'b1;
  endtask

  task automatic bus_read_chk(string req, logic [15:0] a, bit ns);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_nonsec = ns;
    @(negedge clk);
    req_valid = 0;
    check32(req, rd_data, exp_read(a, ns));
  endtask

  task automatic sweep_reads(string req, bit ns);
    for (int r = 0; r < NR; r++) bus_read_chk(req, 16'h1600 + 16'(4 * r), ns);
  endtask

  task automatic do_clear(logic [NI-1:0] c);
    @(negedge clk); pend_clr = c;
    @(negedge clk); pend_clr = '0;
    mlat = mlat & ~c;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NI; i++) begin
      impl_mask[i]   = (i % 7) != 3;
      secure_mask[i] = (i % 3) == 0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check32("R9 rd_data after reset", rd_data, '0);
    rst_n = 1;
    @(negedge clk);
    checkv("R9 pend_out after reset", pend_out, '0);
    sweep_reads("R9 reads after reset", 0);

    // R8 R6 R7: non-secure all-ones write, read back both ways
    for (int r = 0; r < NR; r++) bus_write(16'h1600 + 16'(4 * r), 32'hFFFF_FFFF, 1, '0);
    sweep_reads("R8 nonsec view", 1);
    sweep_reads("R6 R7 secure view", 0);
    checkv("R10 pend_out after ns writes", pend_out, exp_pend());

    // R2: write zero no effect, then secure write sets rest
    for (int r = 0; r < NR; r++) bus_write(16'h1600 + 16'(4 * r), 32'h0, 0, '0);
    sweep_reads("R2 write zero", 0);
    for (int r = 0; r < NR; r++) bus_write(16'h1600 + 16'(4 * r), 32'hA5A5_5A5A, 0, '0);
    sweep_reads("R2 secure pattern", 0);
    do_clear({NI{1'b1}});
    sweep_reads("R4 full clear", 0);

    // R8: sec_disable lets non-secure reach secure bits
    sec_disable = 1;
    bus_write(16'h1600, 32'h0000_FFFF, 1, '0);
    sweep_reads("R8 sec_disable nonsec", 1);
    sec_disable = 0;
    sweep_reads("R8 enforcement back on", 1);
    do_clear({NI{1'b1}});

    // R3 R4: level OR latch, latch survives line drop
    irq_level = '0;
    for (int i = 0; i < NI; i += 5) irq_level[i] = 1'b1;
    sweep_reads("R3 level only", 0);
    bus_write(16'h1600, 32'h0000_0021, 0, '0);
    bus_write(16'h1604, 32'h8000_0002, 0, '0);
    sweep_reads("R2 set while level high", 0);
    irq_level = '0;
    sweep_reads("R4 after line drop", 0);
    checkv("R4 pend_out after line drop", pend_out, exp_pend());
    do_clear(128'h1);
    sweep_reads("R4 partial clear", 0);

    // R5: set and clear collide on one bit
    bus_write(16'h1604, 32'h0000_0010, 0, 128'h1 << 36);
    sweep_reads("R5 set wins", 0);
    checkv("R5 pend_out", pend_out, exp_pend());

    // R10: active-and-pending
    active_in = '0;
    for (int i = 0; i < NI; i += 2) active_in[i] = 1'b1;
    @(negedge clk);
    checkv("R10 act_pend_out", act_pend_out, exp_pend() & active_in);

    // R1: out-of-window addresses
    bus_write(16'h15FC, 32'hFFFF_FFFF, 0, '0);
    bus_write(16'h1610, 32'hFFFF_FFFF, 0, '0);
    bus_write(16'h1602, 32'hFFFF_FFFF, 0, '0);
    sweep_reads("R1 after stray writes", 0);
    bus_read_chk("R1 below base", 16'h15FC, 0);
    bus_read_chk("R1 above window", 16'h1610, 0);
    bus_read_chk("R1 misaligned", 16'h1601, 0);
    bus_read_chk("R1 real reg after miss", 16'h1604, 0);

    // R6: range disabled
    ext_en = 0;
    bus_write(16'h1608, 32'hFFFF_FFFF, 0, '0);
    sweep_reads("R6 ext disabled", 0);
    checkv("R6 pend_out disabled", pend_out, '0);
    ext_en = 1;
    sweep_reads("R6 re-enabled unchanged", 0);
    range_cfg = 2'd3;
    bus_write(16'h160C, 32'h0F0F_0F0F, 0, '0);
    sweep_reads("R6 full range", 0);
    checkv("R7 pend_out full range", pend_out, exp_pend());

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule